// File: doc/BRIEF.md
# Peripheral bus target phase sequencer

This block is the target side of a shared, ID-selected parallel peripheral bus. While the bus is free it watches the selection lines. When it sees itself addressed it claims the bus by raising its busy line. It then steps the initiator through a fixed sequence of bus phases: a six-byte command, an optional block of data bytes in either direction, one status byte and one message byte. Finally it releases every line it drives, which leaves the bus free again.

Each phase is announced on three phase lines: control/data, direction and message. Every byte crosses the bus with a full interlocked request/acknowledge handshake. The command bytes are kept and broken out into fields for the local logic. Data bytes for the initiator are taken from a local read port. Bytes from the initiator are handed out on a local write port, one strobe per byte. The status byte comes from a local input.

Top module: `pbus_target_seq`

## Requirements
- R1: When the bus is free and the block sees select high, its own ID bit (bit OWN_ID of `id_i`) high, `bus_busy_i` low and `bus_dir_i` low at a clock edge, `busy_o` is high from the next cycle.
- R2: While free, the block ignores selection when select is low, its own ID bit is low, `bus_busy_i` is high or `bus_dir_i` is high: `busy_o` stays low.
- R3: The command phase drives {ctl,dir,msg} = 3'b100 and takes six bytes. Byte 0 appears on `cmd_opcode_o`, byte 1 on `cmd_unit_o`, bytes 2 and 3 on `cmd_blk_o` (byte 2 in the upper half), byte 4 on `cmd_len_o` and byte 5 on `cmd_ctrl_o`. `cmd_valid_o` pulses once per command.
- R4: For each byte, `req_o` rises and stays high until `ack_i` is seen high. It falls in the next cycle and does not rise again while `ack_i` stays high.
- R5: If the opcode bit 0 is 1 and the length is not zero, a data-in phase with {ctl,dir,msg} = 3'b010 sends exactly length bytes taken from `rd_data_i`. `rd_pop_o` pulses once per byte sent, and `wr_valid_o` never pulses.
- R6: If the opcode bit 0 is 0 and the length is not zero, a data-out phase with {ctl,dir,msg} = 3'b000 takes exactly length bytes. Each byte is presented on `wr_data_o` with a one-cycle `wr_valid_o`, in the order received.
- R7: A length byte of zero skips the data phase: the byte after the command is a status byte. Neither `rd_pop_o` nor `wr_valid_o` pulses.
- R8: The status phase drives {ctl,dir,msg} = 3'b110 and sends the value on `status_i` as one byte.
- R9: The message-in phase drives {ctl,dir,msg} = 3'b111 and sends one byte equal to MSG_DONE (default 8'h00). In the cycle after its handshake completes, `busy_o`, `req_o` and all three phase lines are low.
- R10: The phase lines never change while `req_o` is high, and they are all low whenever `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Bus select line |
| bus_busy_i | input | 1 | Busy line as driven by other agents |
| bus_dir_i | input | 1 | Direction line as seen during selection |
| id_i | input | ID_W | Bus ID bits during selection |
| ack_i | input | 1 | Initiator acknowledge |
| data_i | input | 8 | Byte from the initiator |
| status_i | input | 8 | Status byte to return |
| rd_data_i | input | 8 | Next local byte for a data-in phase |
| busy_o | output | 1 | Bus claimed by this target |
| req_o | output | 1 | Byte request |
| ctl_o | output | 1 | Control/data phase line |
| dir_o | output | 1 | Direction phase line (1 = target to initiator) |
| msg_o | output | 1 | Message phase line |
| data_o | output | 8 | Byte to the initiator |
| rd_pop_o | output | 1 | One local read byte consumed |
| wr_data_o | output | 8 | Byte received in data-out phase |
| wr_valid_o | output | 1 | `wr_data_o` valid for one cycle |
| cmd_valid_o | output | 1 | Command block complete |
| cmd_opcode_o | output | 8 | Command byte 0 |
| cmd_unit_o | output | 8 | Command byte 1 |
| cmd_blk_o | output | 16 | Command bytes 2 and 3 |
| cmd_len_o | output | 8 | Command byte 4 |
| cmd_ctrl_o | output | 8 | Command byte 5 |

## Verification
The assertions watch the bus rules on every cycle. They check that busy follows a valid selection and nothing else, and that the request is held until acknowledged and then dropped. They also check that the phase lines and outgoing data stay stable under a pending request, that the message encoding is legal, and that the lines are quiet on a free bus. The ordering of whole phases can only be shown by the bench scenarios: the field decoding of the command block, the byte counts set by the length field, the skipped data phase at length zero, the data values in each direction, and the release after the message byte. The bench also sweeps every combination of the four selection conditions.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    localparam int BYTE_W    = 8;
    localparam int CMD_BYTES = 6;
    localparam int CMD_IDX_W = $clog2(CMD_BYTES);

    typedef enum logic [2:0] {
        PH_FREE,
        PH_CMD,
        PH_DIN,
        PH_DOUT,
        PH_STAT,
        PH_MSGI
    } phase_e;

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_WAIT_ACK,
        HS_WAIT_REL
    } hs_e;

    typedef struct packed {
        logic ctl;
        logic dir;
        logic msg;
    } lines_t;

    typedef struct packed {
        logic [BYTE_W-1:0]   opcode;
        logic [BYTE_W-1:0]   unit;
        logic [2*BYTE_W-1:0] blk;
        logic [BYTE_W-1:0]   len;
        logic [BYTE_W-1:0]   ctrl;
    } cdb_t;

    function automatic lines_t phase_lines(phase_e p);
        lines_t l;
        case (p)
            PH_CMD:  l = '{ctl: 1'b1, dir: 1'b0, msg: 1'b0};
            PH_DIN:  l = '{ctl: 1'b0, dir: 1'b1, msg: 1'b0};
            PH_STAT: l = '{ctl: 1'b1, dir: 1'b1, msg: 1'b0};
            PH_MSGI: l = '{ctl: 1'b1, dir: 1'b1, msg: 1'b1};
            default: l = '{ctl: 1'b0, dir: 1'b0, msg: 1'b0};
        endcase
        return l;
    endfunction

    function automatic logic opcode_reads(logic [BYTE_W-1:0] op);
        return op[0];
    endfunction

endpackage

// File: rtl/pbus_sel_detect.sv
module pbus_sel_detect #(
    parameter int ID_W   = 8,
    parameter int OWN_ID = 3
) (
    input  logic            sel_i,
    input  logic            bus_busy_i,
    input  logic            bus_dir_i,
    input  logic [ID_W-1:0] id_i,
    output logic            hit_o
);
    localparam logic [ID_W-1:0] OWN_MASK = ID_W'(1) << OWN_ID;

    always_comb begin
        hit_o = sel_i && ((id_i & OWN_MASK) != '0) && !bus_busy_i && !bus_dir_i;
    end
endmodule

// File: rtl/pbus_handshake.sv
module pbus_handshake
    import pbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic [BYTE_W-1:0] tx_i,
    input  logic              ack_i,
    input  logic [BYTE_W-1:0] rx_i,
    output logic              req_o,
    output logic [BYTE_W-1:0] tx_o,
    output logic [BYTE_W-1:0] rx_o,
    output logic              done_o
);
    hs_e hs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q <= HS_IDLE;
            tx_o <= '0;
            rx_o <= '0;
        end else begin
            case (hs_q)
                HS_IDLE: if (en_i) begin
                    tx_o <= tx_i;
                    hs_q <= HS_WAIT_ACK;
                end
                HS_WAIT_ACK: if (ack_i) begin
                    rx_o <= rx_i;
                    hs_q <= HS_WAIT_REL;
                end
                HS_WAIT_REL: if (!ack_i) hs_q <= HS_IDLE;
                default: hs_q <= HS_IDLE;
            endcase
        end
    end

    assign req_o  = (hs_q == HS_WAIT_ACK);
    assign done_o = (hs_q == HS_WAIT_REL) && !ack_i;
endmodule

// File: rtl/pbus_phase_ctl.sv
module pbus_phase_ctl
    import pbus_pkg::*;
#(
    parameter logic [7:0] MSG_DONE = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit_i,
    input  logic              done_i,
    input  logic [BYTE_W-1:0] rx_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    input  logic [BYTE_W-1:0] status_i,
    output phase_e            phase_o,
    output logic              en_o,
    output logic [BYTE_W-1:0] tx_o,
    output cdb_t              cdb_o,
    output logic              cmd_valid_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              wr_valid_o,
    output logic              rd_pop_o
);
    phase_e            phase_q;
    logic [BYTE_W-1:0] cnt_q;
    logic [BYTE_W-1:0] bytes_q [CMD_BYTES];
    logic              last_data;

    assign phase_o   = phase_q;
    assign en_o      = (phase_q != PH_FREE);
    assign last_data = (cnt_q == bytes_q[4] - BYTE_W'(1));

    always_comb begin
        case (phase_q)
            PH_DIN:  tx_o = rd_data_i;
            PH_STAT: tx_o = status_i;
            PH_MSGI: tx_o = MSG_DONE;
            default: tx_o = '0;
        endcase
    end

    assign cdb_o = '{opcode: bytes_q[0], unit: bytes_q[1],
                     blk: {bytes_q[2], bytes_q[3]},
                     len: bytes_q[4], ctrl: bytes_q[5]};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_FREE;
            cnt_q       <= '0;
            cmd_valid_o <= 1'b0;
            wr_valid_o  <= 1'b0;
            wr_data_o   <= '0;
            rd_pop_o    <= 1'b0;
            for (int i = 0; i < CMD_BYTES; i++) bytes_q[i] <= '0;
        end else begin
            cmd_valid_o <= 1'b0;
            wr_valid_o  <= 1'b0;
            rd_pop_o    <= 1'b0;
            case (phase_q)
                PH_FREE: if (hit_i) begin
                    phase_q <= PH_CMD;
                    cnt_q   <= '0;
                end
                PH_CMD: if (done_i) begin
                    bytes_q[cnt_q[CMD_IDX_W-1:0]] <= rx_i;
                    if (cnt_q == BYTE_W'(CMD_BYTES - 1)) begin
                        cnt_q       <= '0;
                        cmd_valid_o <= 1'b1;
                        if (bytes_q[4] == '0)             phase_q <= PH_STAT;
                        else if (opcode_reads(bytes_q[0])) phase_q <= PH_DIN;
                        else                               phase_q <= PH_DOUT;
                    end else begin
                        cnt_q <= cnt_q + BYTE_W'(1);
                    end
                end
                PH_DIN, PH_DOUT: if (done_i) begin
                    if (phase_q == PH_DIN) begin
                        rd_pop_o <= 1'b1;
                    end else begin
                        wr_valid_o <= 1'b1;
                        wr_data_o  <= rx_i;
                    end
                    if (last_data) begin
                        cnt_q   <= '0;
                        phase_q <= PH_STAT;
                    end else begin
                        cnt_q <= cnt_q + BYTE_W'(1);
                    end
                end
                PH_STAT: if (done_i) phase_q <= PH_MSGI;
                PH_MSGI: if (done_i) phase_q <= PH_FREE;
                default: phase_q <= PH_FREE;
            endcase
        end
    end
endmodule

// File: rtl/pbus_target_seq.sv
module pbus_target_seq
    import pbus_pkg::*;
#(
    parameter int         ID_W     = 8,
    parameter int         OWN_ID   = 3,
    parameter logic [7:0] MSG_DONE = 8'h00
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sel_i,
    input  logic            bus_busy_i,
    input  logic            bus_dir_i,
    input  logic [ID_W-1:0] id_i,
    input  logic            ack_i,
    input  logic [7:0]      data_i,
    input  logic [7:0]      status_i,
    input  logic [7:0]      rd_data_i,
    output logic            busy_o,
    output logic            req_o,
    output logic            ctl_o,
    output logic            dir_o,
    output logic            msg_o,
    output logic [7:0]      data_o,
    output logic            rd_pop_o,
    output logic [7:0]      wr_data_o,
    output logic            wr_valid_o,
    output logic            cmd_valid_o,
    output logic [7:0]      cmd_opcode_o,
    output logic [7:0]      cmd_unit_o,
    output logic [15:0]     cmd_blk_o,
    output logic [7:0]      cmd_len_o,
    output logic [7:0]      cmd_ctrl_o
);
    logic        hit;
    logic        en;
    logic        done;
    logic [7:0]  tx_byte;
    logic [7:0]  rx_byte;
    phase_e      phase;
    cdb_t        cdb;
    lines_t      lines;

    pbus_sel_detect #(.ID_W(ID_W), .OWN_ID(OWN_ID)) u_sel (
        .sel_i      (sel_i),
        .bus_busy_i (bus_busy_i),
        .bus_dir_i  (bus_dir_i),
        .id_i       (id_i),
        .hit_o      (hit)
    );

    pbus_phase_ctl #(.MSG_DONE(MSG_DONE)) u_ctl (
        .clk         (clk),
        .rst         (rst),
        .hit_i       (hit),
        .done_i      (done),
        .rx_i        (rx_byte),
        .rd_data_i   (rd_data_i),
        .status_i    (status_i),
        .phase_o     (phase),
        .en_o        (en),
        .tx_o        (tx_byte),
        .cdb_o       (cdb),
        .cmd_valid_o (cmd_valid_o),
        .wr_data_o   (wr_data_o),
        .wr_valid_o  (wr_valid_o),
        .rd_pop_o    (rd_pop_o)
    );

    pbus_handshake u_hs (
        .clk    (clk),
        .rst    (rst),
        .en_i   (en),
        .tx_i   (tx_byte),
        .ack_i  (ack_i),
        .rx_i   (data_i),
        .req_o  (req_o),
        .tx_o   (data_o),
        .rx_o   (rx_byte),
        .done_o (done)
    );

    assign lines        = phase_lines(phase);
    assign busy_o       = (phase != PH_FREE);
    assign ctl_o        = lines.ctl;
    assign dir_o        = lines.dir;
    assign msg_o        = lines.msg;
    assign cmd_opcode_o = cdb.opcode;
    assign cmd_unit_o   = cdb.unit;
    assign cmd_blk_o    = cdb.blk;
    assign cmd_len_o    = cdb.len;
    assign cmd_ctrl_o   = cdb.ctrl;
endmodule

// File: rtl/pbus_target_seq_chk.sv
module pbus_target_seq_chk #(
    parameter int ID_W   = 8,
    parameter int OWN_ID = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            sel_i,
    input logic            bus_busy_i,
    input logic            bus_dir_i,
    input logic [ID_W-1:0] id_i,
    input logic            ack_i,
    input logic            busy_o,
    input logic            req_o,
    input logic            ctl_o,
    input logic            dir_o,
    input logic            msg_o,
    input logic [7:0]      data_o
);
    logic valid_sel;
    assign valid_sel = sel_i && id_i[OWN_ID] && !bus_busy_i && !bus_dir_i;

    p_select_busy_r1: assert property (@(posedge clk) disable iff (rst)
        (valid_sel && !busy_o) |=> busy_o);

    p_ignore_select_r2: assert property (@(posedge clk) disable iff (rst)
        (!valid_sel && !busy_o) |=> !busy_o);

    p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (req_o && !ack_i) |=> req_o);

    p_req_drop_r4: assert property (@(posedge clk) disable iff (rst)
        (req_o && ack_i) |=> !req_o);

    p_data_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (req_o && $past(req_o) && dir_o) |-> $stable(data_o));

    p_msg_code_r9: assert property (@(posedge clk) disable iff (rst)
        msg_o |-> (ctl_o && dir_o));

    p_phase_stable_r10: assert property (@(posedge clk) disable iff (rst)
        req_o |-> $stable({ctl_o, dir_o, msg_o}));

    p_free_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!req_o && !ctl_o && !dir_o && !msg_o));
endmodule

bind pbus_target_seq pbus_target_seq_chk #(.ID_W(ID_W), .OWN_ID(OWN_ID)) u_chk (.*);

// File: tb/pbus_target_seq_tb.sv
`timescale 1ns/1ps
module pbus_target_seq_tb_top;
    localparam int ID_W   = 8;
    localparam int OWN_ID = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_i = 1'b0, bus_busy_i = 1'b0, bus_dir_i = 1'b0, ack_i = 1'b0;
    logic [ID_W-1:0] id_i = '0;
    logic [7:0]  data_i = '0, status_i = '0, rd_data_i = '0;
    logic        busy_o, req_o, ctl_o, dir_o, msg_o, rd_pop_o, wr_valid_o, cmd_valid_o;
    logic [7:0]  data_o, wr_data_o, cmd_opcode_o, cmd_unit_o, cmd_len_o, cmd_ctrl_o;
    logic [15:0] cmd_blk_o;

    int vec = 0, bad = 0;
    bit finished = 0;
    int wr_n = 0, pop_n = 0, cv_n = 0;
    logic [7:0] wr_log [256];
    int rd_k = 0;

    always #2 clk = ~clk;

    pbus_target_seq #(.ID_W(ID_W), .OWN_ID(OWN_ID)) dut_i (.*);

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_valid_o) begin wr_log[wr_n[7:0]] = wr_data_o; wr_n++; end
            if (rd_pop_o) pop_n++;
            if (cmd_valid_o) cv_n++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ibyte(input logic [7:0] wb, input bit slow,
                         output logic [7:0] rb, output logic [2:0] ph);
        int n = 0;
        while (!req_o && n < 200) begin @(negedge clk); n++; end
        chk("R4 request arrives", {31'd0, req_o}, 32'd1);
        ph = {ctl_o, dir_o, msg_o};
        rb = data_o;
        if (slow) begin
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                chk("R4 request held without ack", {31'd0, req_o}, 32'd1);
            end
        end
        data_i = wb;
        ack_i  = 1'b1;
        @(negedge clk);
        chk("R4 request drops after ack", {31'd0, req_o}, 32'd0);
        if (slow) begin
            for (int i = 0; i < 2; i++) begin
                @(negedge clk);
                chk("R4 no request while ack high", {31'd0, req_o}, 32'd0);
            end
        end
        if (ph == 3'b010) begin
            rd_k++;
            rd_data_i = 8'hA0 + rd_k[7:0];
        end
        ack_i = 1'b0;
    endtask

    task automatic run_txn(input logic [7:0] op, input logic [7:0] len,
                           input logic [7:0] stat, input bit slow);
        logic [7:0] cb [6];
        logic [7:0] rb;
        logic [2:0] ph;
        cb[0] = op; cb[1] = 8'h20 + len; cb[2] = 8'h12 ^ op;
        cb[3] = 8'h34 + len; cb[4] = len; cb[5] = 8'hC0 | op;
        rd_k = 0; rd_data_i = 8'hA0; status_i = stat;
        wr_n = 0; pop_n = 0; cv_n = 0;
        @(negedge clk);
        sel_i = 1'b1; id_i = ID_W'(1) << OWN_ID; bus_busy_i = 1'b0; bus_dir_i = 1'b0;
        @(negedge clk);
        chk("R1 busy one cycle after selection", {31'd0, busy_o}, 32'd1);
        sel_i = 1'b0; id_i = '0;
        for (int i = 0; i < 6; i++) begin
            ibyte(cb[i], slow && (i == 0), rb, ph);
            chk("R3 command phase lines", {29'd0, ph}, 32'b100);
        end
        for (int k = 0; k < int'(len); k++) begin
            ibyte(8'h50 + k[7:0], slow && (k == 0), rb, ph);
            if (op[0]) begin
                chk("R5 data-in phase lines", {29'd0, ph}, 32'b010);
                chk("R5 data-in byte value", {24'd0, rb}, {24'd0, 8'hA0 + k[7:0]});
            end else begin
                chk("R6 data-out phase lines", {29'd0, ph}, 32'b000);
            end
        end
        ibyte(8'h00, 1'b0, rb, ph);
        if (len == 0) chk("R7 zero length goes to status", {29'd0, ph}, 32'b110);
        chk("R8 status phase lines", {29'd0, ph}, 32'b110);
        chk("R8 status byte", {24'd0, rb}, {24'd0, stat});
        ibyte(8'h00, 1'b0, rb, ph);
        chk("R9 message phase lines", {29'd0, ph}, 32'b111);
        chk("R9 message byte", {24'd0, rb}, 32'h00);
        @(negedge clk);
        chk("R9 bus released", {27'd0, busy_o, req_o, ctl_o, dir_o, msg_o}, 32'd0);
        chk("R3 opcode field", {24'd0, cmd_opcode_o}, {24'd0, cb[0]});
        chk("R3 unit field", {24'd0, cmd_unit_o}, {24'd0, cb[1]});
        chk("R3 block field", {16'd0, cmd_blk_o}, {16'd0, cb[2], cb[3]});
        chk("R3 length field", {24'd0, cmd_len_o}, {24'd0, cb[4]});
        chk("R3 control field", {24'd0, cmd_ctrl_o}, {24'd0, cb[5]});
        chk("R3 one command strobe", cv_n, 32'd1);
        if (len == 0) begin
            chk("R7 no read pops", pop_n, 32'd0);
            chk("R7 no write strobes", wr_n, 32'd0);
        end else if (op[0]) begin
            chk("R5 read pop count", pop_n, {24'd0, len});
            chk("R5 no write strobes", wr_n, 32'd0);
        end else begin
            chk("R6 write strobe count", wr_n, {24'd0, len});
            chk("R6 no read pops", pop_n, 32'd0);
            for (int k = 0; k < int'(len); k++)
                chk("R6 written byte order", {24'd0, wr_log[k]}, {24'd0, 8'h50 + k[7:0]});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] lens [6];
        lens[0] = 0; lens[1] = 1; lens[2] = 2; lens[3] = 5; lens[4] = 16; lens[5] = 255;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 reset state quiet", {27'd0, busy_o, req_o, ctl_o, dir_o, msg_o}, 32'd0);
        chk("R3 no command strobe at reset", {31'd0, cmd_valid_o}, 32'd0);

        for (int c = 0; c < 16; c++) begin
            if (c == 3) continue;
            @(negedge clk);
            sel_i      = c[0];
            id_i       = c[1] ? (ID_W'(1) << OWN_ID) : ~(ID_W'(1) << OWN_ID);
            bus_busy_i = c[2];
            bus_dir_i  = c[3];
            repeat (2) @(negedge clk);
            chk("R2 selection ignored", {31'd0, busy_o}, 32'd0);
            sel_i = 1'b0; id_i = '0; bus_busy_i = 1'b0; bus_dir_i = 1'b0;
        end

        for (int l = 0; l < 6; l++) begin
            run_txn(8'h0A, lens[l], 8'h02 ^ lens[l], l < 2);
            run_txn(8'h0B, lens[l], 8'h10 + lens[l], l < 2);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule